// File: doc/BRIEF.md
# Configurable GPIO Port Controller

This block controls one general-purpose I/O port of `WIDTH` pins, eight by default. It holds an output latch, which the CPU writes either a whole byte at a time or one bit at a time. It also holds a drive-style register that selects, for each pin, open-drain or push-pull drive. From these two registers and a shared pull-up disable input, it produces three signals for each tri-state pad: an output enable, an output value and a weak pull-up enable.

Reads are combinational. A plain read returns the pin levels after a two-flop synchronizer. When the bus marks the read as the read phase of a read-modify-write access, the read returns the latch contents instead, so a bit operation never copies a pin that some other device holds low back into the latch.

A parameter mask marks which pins exist. A missing pin never drives, never pulls up and always reads 0. After reset every pin is released, so it acts as an input with its pull-up on.

Top module: `gpio_port_ctrl`

## Requirements
- R1: With `rd_rmw` low, `rd_data` returns the level that `pin_in` had two rising clock edges earlier, through a two-flop synchronizer.
- R2: With `rd_rmw` high, `rd_data` returns the output latch contents instead of the pin levels.
- R3: A pin whose drive-style bit is 1 (push-pull) has `pad_oe` = 1 and `pad_out` equal to its latch bit.
- R4: A pin whose drive-style bit is 0 (open-drain) has `pad_oe` = 1 and `pad_out` = 0 when its latch bit is 0. When its latch bit is 1 it has `pad_oe` = 0, so it acts as an input.
- R5: Synchronous reset sets the latch to all ones and every drive-style bit to 0. All present pins are then released with their pull-ups on.
- R6: The pull-up on a present pin is on while `pull_dis` is 0 and off on every pin while `pull_dis` is 1.
- R7: A pin that drives a logic 0 has its pull-up off, whatever the value of `pull_dis`.
- R8: A byte write (`wr_en` = 1) loads `wr_data` into the latch when `wr_sel` = 0, or into the drive-style register when `wr_sel` = 1. The new value shows from the next clock edge.
- R9: A bit write (`bit_wr_en` = 1) sets latch bit `bit_idx` to `bit_val` and leaves the other latch bits unchanged. If a latch byte write happens in the same cycle, the bit write wins for its own bit.
- R10: A pin whose bit in `PIN_PRESENT` is 0 never drives, has its pull-up off, and reads 0 on both read paths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| wr_sel | input | 1 | Byte write target: 0 latch, 1 drive-style register |
| wr_data | input | WIDTH | Byte write data |
| bit_wr_en | input | 1 | Single latch bit write strobe |
| bit_idx | input | IDX_W | Index of the latch bit to write |
| bit_val | input | 1 | Value for the indexed latch bit |
| rd_rmw | input | 1 | Read-modify-write read-phase qualifier |
| rd_data | output | WIDTH | Read data |
| pull_dis | input | 1 | Global weak pull-up disable |
| pin_in | input | WIDTH | Pad input levels |
| pad_oe | output | WIDTH | Pad output enable, one bit per pin |
| pad_out | output | WIDTH | Pad output value, one bit per pin |
| pad_pu | output | WIDTH | Pad weak pull-up enable, one bit per pin |

## Verification
The read-path assertion assumes that `pin_in` is an ordinary synchronous signal. A level seen at the synchronizer input is therefore taken to appear on `rd_data` exactly two edges later. The bench honours this by changing `pin_in` only on falling edges. The bit-isolation check assumes `bit_idx` is below `WIDTH`. The bench uses only in-range indices, and it drives every strobe away from the rising edge so that each write lands on a single known edge.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    typedef enum logic {
        TGT_LATCH = 1'b0,
        TGT_STYLE = 1'b1
    } wr_target_e;

    typedef struct packed {
        logic oe;
        logic out;
        logic pu;
    } pad_ctl_t;

    // Per-pin drive decision: push-pull always drives, open-drain only pulls low.
    function automatic pad_ctl_t pad_decide(input logic present, input logic push_pull,
                                            input logic level, input logic pu_off);
        pad_ctl_t c;
        logic drive;
        drive = present & (push_pull | ~level);
        c.oe  = drive;
        c.out = present & level;
        c.pu  = present & ~pu_off & ~(drive & ~level);
        return c;
    endfunction

endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 8,
    localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             bit_wr_en,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic             bit_val,
    output logic [WIDTH-1:0] latch_q,
    output logic [WIDTH-1:0] style_q
);

    wr_target_e tgt;
    logic [WIDTH-1:0] latch_byte;
    logic [WIDTH-1:0] latch_nxt;

    assign tgt = wr_target_e'(wr_sel);

    always_comb begin
        latch_byte = (wr_en && tgt == TGT_LATCH) ? wr_data : latch_q;
        latch_nxt  = latch_byte;
        if (bit_wr_en) begin
            latch_nxt[bit_idx] = bit_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '1;
            style_q <= '0;
        end else begin
            latch_q <= latch_nxt;
            if (wr_en && tgt == TGT_STYLE) begin
                style_q <= wr_data;
            end
        end
    end

    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst;

    always @(posedge clk) begin
        if (rst_d && !rst) begin
            a_r5_reset_values: assert (latch_q == '1 && style_q == '0)
                else $error("R5: registers not at reset values");
        end
    end

    // R9: a lone bit write touches no other latch bit
    a_r9_bit_isolated: assert property (@(posedge clk) disable iff (rst)
        (bit_wr_en && !(wr_en && !wr_sel)) |=>
        (((latch_q ^ $past(latch_q)) & ~(WIDTH'(1) << $past(bit_idx))) == '0));

    // R8: drive-style register changes only on a style byte write
    a_r8_style_hold: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_sel) |=> $stable(style_q));

endmodule

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

endmodule

// File: rtl/gpio_port_pads.sv
module gpio_port_pads
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter logic [WIDTH-1:0] PIN_PRESENT = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] latch_q,
    input  logic [WIDTH-1:0] style_q,
    input  logic             pull_dis,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_pu
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        pad_ctl_t ctl;
        assign ctl        = pad_decide(PIN_PRESENT[i], style_q[i], latch_q[i], pull_dis);
        assign pad_oe[i]  = ctl.oe;
        assign pad_out[i] = ctl.out;
        assign pad_pu[i]  = ctl.pu;
    end

    // R7: never pull up a pin that is being driven low
    a_r7_no_fight: assert property (@(posedge clk) disable iff (rst)
        (pad_oe & ~pad_out & pad_pu) == '0);

    // R3: a push-pull present pin always drives its latch value
    a_r3_push_pull: assert property (@(posedge clk) disable iff (rst)
        ((style_q & PIN_PRESENT & ~pad_oe) == '0) && (((pad_out ^ latch_q) & PIN_PRESENT) == '0));

    // R6: global disable removes every pull-up
    a_r6_global_off: assert property (@(posedge clk) disable iff (rst)
        pull_dis |-> (pad_pu == '0));

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter logic [WIDTH-1:0] PIN_PRESENT = '1,
    localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             bit_wr_en,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic             bit_val,
    input  logic             rd_rmw,
    output logic [WIDTH-1:0] rd_data,
    input  logic             pull_dis,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_pu
);

    logic [WIDTH-1:0] latch_q;
    logic [WIDTH-1:0] style_q;
    logic [WIDTH-1:0] pin_sync;

    gpio_port_regs #(.WIDTH(WIDTH)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .bit_wr_en(bit_wr_en), .bit_idx(bit_idx), .bit_val(bit_val),
        .latch_q(latch_q), .style_q(style_q)
    );

    gpio_port_sync #(.WIDTH(WIDTH)) u_sync (
        .clk(clk), .rst(rst), .d(pin_in), .q(pin_sync)
    );

    gpio_port_pads #(.WIDTH(WIDTH), .PIN_PRESENT(PIN_PRESENT)) u_pads (
        .clk(clk), .rst(rst), .latch_q(latch_q), .style_q(style_q), .pull_dis(pull_dis),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
    );

    assign rd_data = (rd_rmw ? latch_q : pin_sync) & PIN_PRESENT;

    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)                  since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R1: plain reads show the pin level from two edges back
    a_r1_pin_latency: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3 && !rd_rmw) |-> (rd_data == ($past(pin_in, 2) & PIN_PRESENT)));

    // R10: absent pins stay silent on every output
    a_r10_absent_quiet: assert property (@(posedge clk) disable iff (rst)
        ((pad_oe | pad_pu | rd_data) & ~PIN_PRESENT) == '0);

endmodule

// File: tb/test_gpio_port_ctrl.sv
module test_gpio_port_ctrl;

    localparam int W = 8;
    localparam logic [W-1:0] MASK = 8'hEF;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 0, wr_sel = 0, bit_wr_en = 0, bit_val = 0, rd_rmw = 0, pull_dis = 0;
    logic [W-1:0] wr_data = '0, pin_in = '0;
    logic [2:0] bit_idx = '0;
    logic [W-1:0] rd_data, pad_oe, pad_out, pad_pu;

    int checks = 0;
    int fails = 0;

    always #2 clk = ~clk;

    gpio_port_ctrl #(.WIDTH(W), .PIN_PRESENT(MASK)) i_gpio_port_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .bit_wr_en(bit_wr_en), .bit_idx(bit_idx), .bit_val(bit_val), .rd_rmw(rd_rmw),
        .rd_data(rd_data), .pull_dis(pull_dis), .pin_in(pin_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
    );

    // stimulus: {style, latch, pull_dis, pins}
    localparam logic [31:0] VEC [6] = '{
        {8'h00, 8'hFF, 8'h00, 8'hA5},
        {8'hFF, 8'h5A, 8'h00, 8'h3C},
        {8'h0F, 8'h33, 8'h01, 8'hFF},
        {8'hF0, 8'h00, 8'h00, 8'h00},
        {8'hAA, 8'h0F, 8'h01, 8'hC3},
        {8'h00, 8'h00, 8'h00, 8'h81}
    };

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic byte_write(input logic sel, input logic [W-1:0] d);
        wr_en = 1; wr_sel = sel; wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 0;
    endtask

    task automatic bit_write(input logic [2:0] idx, input logic v);
        bit_wr_en = 1; bit_idx = idx; bit_val = v;
        @(posedge clk); @(negedge clk);
        bit_wr_en = 0;
    endtask

    // expected pad vectors from R3, R4, R6, R7, R10
    function automatic logic [3*W-1:0] model(input logic [W-1:0] sty, input logic [W-1:0] lat,
                                             input logic pd);
        logic [W-1:0] oe, out, pu;
        for (int i = 0; i < W; i++) begin
            if (!MASK[i]) begin
                oe[i] = 0; out[i] = 0; pu[i] = 0;
            end else begin
                oe[i]  = sty[i] | ~lat[i];
                out[i] = lat[i];
                pu[i]  = ~pd & ~(oe[i] & ~lat[i]);
            end
        end
        return {oe, out, pu};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;
        // R5: reset state
        check("R5 oe", pad_oe, 8'h00);
        check("R5 pu", pad_pu, MASK);
        rd_rmw = 1; #0;
        check("R5 latch", rd_data, 8'hFF & MASK);
        rd_rmw = 0;

        // table walk: R2 R3 R4 R6 R7 R8 R1
        for (int k = 0; k < 6; k++) begin
            logic [W-1:0] sty, lat, pins;
            logic pd;
            {sty, lat} = VEC[k][31:16];
            pd = VEC[k][8];
            pins = VEC[k][7:0];
            byte_write(1'b1, sty);
            byte_write(1'b0, lat);
            pull_dis = pd; pin_in = pins;
            repeat (2) @(negedge clk);
            check("R3/R4 oe", pad_oe, model(sty, lat, pd)[3*W-1:2*W]);
            check("R3/R4 out", pad_out, model(sty, lat, pd)[2*W-1:W]);
            check("R6/R7 pu", pad_pu, model(sty, lat, pd)[W-1:0]);
            check("R1 pin read", rd_data, pins & MASK);
            rd_rmw = 1; #0;
            check("R2/R8 rmw read", rd_data, lat & MASK);
            rd_rmw = 0;
        end

        // R1: exact two-edge latency
        pin_in = 8'h0F; repeat (2) @(negedge clk);
        pin_in = 8'hF0;
        @(negedge clk);
        check("R1 after one edge", rd_data, 8'h0F & MASK);
        @(negedge clk);
        check("R1 after two edges", rd_data, 8'hF0 & MASK);

        // R9: bit write isolation and priority over byte write
        pull_dis = 0;
        byte_write(1'b1, 8'h00);
        byte_write(1'b0, 8'h00);
        bit_write(3'd3, 1'b1);
        rd_rmw = 1; #0;
        check("R9 set bit3", rd_data, 8'h08);
        rd_rmw = 0;
        bit_write(3'd3, 1'b0);
        bit_write(3'd6, 1'b1);
        rd_rmw = 1; #0;
        check("R9 bit6 only", rd_data, 8'h40);
        rd_rmw = 0;
        wr_en = 1; wr_sel = 0; wr_data = 8'h0F;
        bit_wr_en = 1; bit_idx = 3'd1; bit_val = 0;
        @(posedge clk); @(negedge clk);
        wr_en = 0; bit_wr_en = 0;
        rd_rmw = 1; #0;
        check("R9 bit wins over byte", rd_data, 8'h0D);
        rd_rmw = 0;

        // R10: absent pin 4 with latch 0 never drives; reads 0
        byte_write(1'b0, 8'h00);
        pin_in = 8'hFF; repeat (2) @(negedge clk);
        check("R10 oe", pad_oe, MASK);
        check("R10 pu", pad_pu, 8'h00);
        check("R10 read", rd_data, MASK);
        bit_write(3'd4, 1'b1);
        rd_rmw = 1; #0;
        check("R10 rmw read", rd_data, 8'h00);
        rd_rmw = 0;

        // R7 with pull-up enabled: low-driving pins lose pull-up, released ones keep it
        byte_write(1'b0, 8'hF0);
        check("R7 pu", pad_pu, 8'hE0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule